// File: doc/BRIEF.md
# Six-Channel Compare Timer

The block is a bus-mapped timer with six independent up-counters, numbered 1 to 6. A simple register bus reaches each channel through four words: control, clock select, a counter that reads back live, and a compare value. Each channel counts ticks of one of two reference tick-enable inputs, fast or slow. A per-channel prescaler can halve the tick rate. A channel runs in one of three modes. In one-shot mode it fires once and stops. In repeat mode it fires and then restarts from zero. In free-run mode it counts forever and never fires.

When a channel fires, it sets a pending flag in a shared status word. Software clears a flag by writing a one to its bit. A shared mask word decides which pending flags reach the single level-sensitive interrupt output. Software typically arms a channel in one write that sets enable and clear together, waits for the interrupt, and then acknowledges it.

Top module: `multi_timer`

## Requirements
- R1: Word-aligned offsets decode as follows. The interrupt mask is at 0x00, bits [5:0], and reads back. Channel n (1..6) has control at 0x10·n, clock select at 0x10·n+4, counter at 0x10·n+8 and compare at 0x10·n+0xC. Compare is fully read/write. Clock select keeps bit 4 and bits [3:0] and reads other bits as 0. Offsets 0x04 and 0x0C, channels 0 and 7 and above, and any address with bits [1:0] not zero read as 0 and ignore writes.
- R2: In control, bit 0 is run-enable and bits [5:4] are the mode: 0 one-shot, 1 repeat, 3 free-run, 2 behaves as free-run. Bit 1 always reads 0. Writes to the counter word are ignored.
- R3: While enabled, a repeat channel advances by one on each selected tick. A tick that finds the counter equal to compare sets the channel's pending flag and returns the counter to 0. The period is therefore compare+1 ticks.
- R4: In one-shot mode, the tick that finds the counter equal to compare sets the pending flag, clears the run-enable bit, and leaves the counter at the compare value.
- R5: In free-run mode the counter wraps from all-ones to zero and never sets its pending flag, whatever the compare value.
- R6: With run-enable 0, ticks leave the counter unchanged, and the mode and compare settings are kept. Setting enable again without clear resumes from the held count.
- R7: A control write with bit 1 set zeroes the counter and the prescaler phase on that clock edge. This takes priority over a tick in the same cycle.
- R8: Clock-select bit 4 = 0 counts the fast tick input; 1 counts the slow one. The unselected input has no effect.
- R9: Divider code 1 in clock-select bits [3:0] advances the counter on every second selected tick, counted from the last clear. Every other code advances on every tick.
- R10: Reading 0x08 returns the six pending flags in bits [5:0], bit n-1 for channel n. Writing 0x08 clears each flag whose bit is 1 and leaves the others. Writing 0x3F clears all of them.
- R11: If a channel fires in the same cycle that its flag is acknowledged, the flag stays set.
- R12: A pending flag is set regardless of the mask. The interrupt output is high exactly when some channel has both its pending and mask bits set.
- R13: After reset every register, counter and flag is 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast reference tick enable |
| tick_slow | input | 1 | Slow reference tick enable |
| addr | input | AW (8) | Byte address of the register word |
| wr_en | input | 1 | Write strobe for the addressed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The collision of interest is a channel firing on the same edge as a bus write that acknowledges its flag. The bench sets up a repeat channel with compare 0, so it fires on every fast tick, and holds the fast tick high while the acknowledge write lands. The flag must read back as set afterwards, and a second acknowledge with the ticks stopped must clear it. A control write with clear set, arriving together with a tick, is a second collision; the counter must read 0 rather than 1.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_RSVD   = 2'd2,
    MODE_FREE   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_CLK  = 2'd1,
    SLOT_CNT  = 2'd2,
    SLOT_CMP  = 2'd3
  } slot_e;

  // free-running modes never compare
  function automatic logic is_free(mode_e m);
    return (m == MODE_FREE) || (m == MODE_RSVD);
  endfunction

  // only divider code 1 halves the tick rate
  function automatic logic div_by2(logic [3:0] code);
    return code == 4'd1;
  endfunction
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale import mtmr_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_fast,
  input  logic       tick_slow,
  input  logic       src_slow,
  input  logic [3:0] div_code,
  input  logic       run,
  input  logic       restart,
  output logic       adv
);
  logic tk, half, phase_q;

  assign tk   = src_slow ? tick_slow : tick_fast;
  assign half = div_by2(div_code);
  assign adv  = tk && (!half || phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   phase_q <= 1'b0;
    else if (restart)             phase_q <= 1'b0;
    else if (tk && half && run)   phase_q <= ~phase_q;
  end

  // R9: in halving mode two advances never come on consecutive cycles
  p_half_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && half && run && !restart) |=> !(adv && half));
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel import mtmr_pkg::*; #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic          ctrl_wr,
  input  logic          clk_wr,
  input  logic          cmp_wr,
  input  logic          w_en,
  input  logic          w_clr,
  input  logic [1:0]    w_mode,
  input  logic          w_src,
  input  logic [3:0]    w_div,
  input  logic [CW-1:0] w_cmp,
  output logic          en,
  output mode_e         mode,
  output logic          src,
  output logic [3:0]    div,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp,
  output logic          evt
);
  logic clr_wr, adv, hit;

  assign clr_wr = ctrl_wr && w_clr;

  mtmr_prescale u_ps (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_fast(tick_fast),
    .tick_slow(tick_slow),
    .src_slow (src),
    .div_code (div),
    .run      (en),
    .restart  (clr_wr),
    .adv      (adv)
  );

  // compare event: named wire brought out for the shared flag logic
  assign hit = adv && en && !clr_wr && !is_free(mode) && (cnt == cmp);
  assign evt = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= MODE_ONCE;
      src  <= 1'b0;
      div  <= '0;
      cmp  <= '0;
    end else begin
      if (ctrl_wr) begin
        en   <= w_en;
        mode <= mode_e'(w_mode);
      end else if (hit && mode == MODE_ONCE) begin
        en   <= 1'b0;
      end
      if (clk_wr) begin
        src <= w_src;
        div <= w_div;
      end
      if (cmp_wr) cmp <= w_cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr_wr)         cnt <= '0;
    else if (hit) begin
      if (mode == MODE_REPEAT) cnt <= '0;
    end else if (adv && en)  cnt <= cnt + 1'b1;
  end

  p_freerun_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_free(mode) |-> !evt);
  p_repeat_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode == MODE_REPEAT) |=> (cnt == '0));
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode == MODE_ONCE && !ctrl_wr) |=> (!en && $stable(cnt)));
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0));
  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr_wr) |=> $stable(cnt));
endmodule

// File: rtl/multi_timer.sv
module multi_timer import mtmr_pkg::*; #(
  parameter int NCH = 6,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam int CIW = AW - 4;

  logic [CIW-1:0] chan;
  slot_e          slot;
  logic           aligned, glob, ien_wr, ack_wr;
  logic [NCH-1:0] ien_q, pend_q, evt_w, ack_mask;

  logic          ch_en   [NCH];
  mode_e         ch_mode [NCH];
  logic          ch_src  [NCH];
  logic [3:0]    ch_div  [NCH];
  logic [CW-1:0] ch_cnt  [NCH];
  logic [CW-1:0] ch_cmp  [NCH];

  assign chan    = addr[AW-1:4];
  assign slot    = slot_e'(addr[3:2]);
  assign aligned = (addr[1:0] == 2'b00);
  assign glob    = aligned && (chan == '0);
  assign ien_wr  = wr_en && glob && (slot == SLOT_CTRL);
  assign ack_wr  = wr_en && glob && (slot == SLOT_CNT);
  assign ack_mask = ack_wr ? wdata[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en && aligned && (chan == CIW'(g + 1));

    mtmr_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_fast(tick_fast),
      .tick_slow(tick_slow),
      .ctrl_wr  (sel && slot == SLOT_CTRL),
      .clk_wr   (sel && slot == SLOT_CLK),
      .cmp_wr   (sel && slot == SLOT_CMP),
      .w_en     (wdata[0]),
      .w_clr    (wdata[1]),
      .w_mode   (wdata[5:4]),
      .w_src    (wdata[4]),
      .w_div    (wdata[3:0]),
      .w_cmp    (wdata[CW-1:0]),
      .en       (ch_en[g]),
      .mode     (ch_mode[g]),
      .src      (ch_src[g]),
      .div      (ch_div[g]),
      .cnt      (ch_cnt[g]),
      .cmp      (ch_cmp[g]),
      .evt      (evt_w[g])
    );

    // R11: an event always leaves its flag set, acknowledge or not
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt_w[g] |=> pend_q[g]);
    // R10: an acknowledged flag with no new event is gone next cycle
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mask[g] && !evt_w[g]) |=> !pend_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (ien_wr) ien_q <= wdata[NCH-1:0];
      pend_q <= (pend_q & ~ack_mask) | evt_w;
    end
  end

  assign irq = |(pend_q & ien_q);

  always_comb begin
    rdata = '0;
    if (glob) begin
      if (slot == SLOT_CTRL)     rdata[NCH-1:0] = ien_q;
      else if (slot == SLOT_CNT) rdata[NCH-1:0] = pend_q;
    end else if (aligned) begin
      for (int i = 0; i < NCH; i++) begin
        if (chan == CIW'(i + 1)) begin
          case (slot)
            SLOT_CTRL: begin
              rdata[0]   = ch_en[i];
              rdata[5:4] = ch_mode[i];
            end
            SLOT_CLK: begin
              rdata[4]   = ch_src[i];
              rdata[3:0] = ch_div[i];
            end
            SLOT_CNT: rdata[CW-1:0] = ch_cnt[i];
            default:  rdata[CW-1:0] = ch_cmp[i];
          endcase
        end
      end
    end
  end

  // R12: with the mask empty no pending flag can raise the interrupt
  p_mask_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/sim_multi_timer.sv
module sim_multi_timer;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_n;
  logic        irq, irq_n;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  multi_timer u0 (.clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
                  .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));
  // narrow-counter copy for the wrap case, same bus
  multi_timer #(.CW(8)) u1 (.clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
                  .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata_n), .irq(irq_n));

  // {addr, write data, expected read-back}
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_003F},
    {8'h00, 32'h0000_0015, 32'h0000_0015},
    {8'h10, 32'h0000_0033, 32'h0000_0031},
    {8'h10, 32'h0000_0020, 32'h0000_0020},
    {8'h14, 32'hFFFF_FFFF, 32'h0000_001F},
    {8'h24, 32'h0000_0001, 32'h0000_0001},
    {8'h1C, 32'h1234_5678, 32'h1234_5678},
    {8'h18, 32'h0000_ABCD, 32'h0000_0000},
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h6C, 32'h0000_00FF, 32'h0000_00FF},
    {8'h70, 32'h0000_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n, input bit slow);
    if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
    repeat (n) @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // expected repeat-mode count after n ticks from zero
  function automatic logic [31:0] rep_count(input int n, input int cmpv);
    return 32'(n % (cmpv + 1));
  endfunction

  initial begin
    #(CYC * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    do_reset();

    // R13 reset state
    rd(8'h00, v); check("R13 mask", v, 0);
    rd(8'h08, v); check("R13 pending", v, 0);
    rd(8'h10, v); check("R13 ctrl", v, 0);
    rd(8'h38, v); check("R13 count", v, 0);
    rd(8'h6C, v); check("R13 compare", v, 0);
    check("R13 irq", {31'b0, irq}, 0);

    // R1 R2 register map table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check($sformatf("R1/R2 vec%0d", i), v, VEC[i][31:0]);
    end
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R1 misaligned write ignored", v, 32'h20);

    do_reset();

    // R3 repeat, R12 masking, R10 acknowledge
    wr(8'h1C, 4);
    wr(8'h10, 32'h13);
    ticks(7, 0);
    rd(8'h18, v); check("R3 count after 7", v, rep_count(7, 4));
    rd(8'h08, v); check("R3 pending set", v, 1);
    check("R12 masked irq low", {31'b0, irq}, 0);
    wr(8'h00, 1);
    check("R12 irq high", {31'b0, irq}, 1);
    wr(8'h08, 32'h3E);
    rd(8'h08, v); check("R10 zero bit no effect", v, 1);
    wr(8'h08, 1);
    rd(8'h08, v); check("R10 ack clears", v, 0);
    check("R12 irq drops", {31'b0, irq}, 0);
    ticks(13, 0);
    rd(8'h18, v); check("R3 count after 20", v, rep_count(20, 4));

    // R6 stop and resume
    wr(8'h10, 32'h10);
    rd(8'h18, c0);
    ticks(5, 0);
    rd(8'h18, v); check("R6 held", v, c0);
    rd(8'h10, v); check("R6 mode kept", v, 32'h10);
    rd(8'h1C, v); check("R6 compare kept", v, 4);
    wr(8'h10, 32'h11);
    ticks(3, 0);
    rd(8'h18, v); check("R6 resumed", v, c0 + 3);
    wr(8'h10, 32'h10);
    wr(8'h08, 32'h3F);

    // R4 one-shot on channel 2
    wr(8'h2C, 3);
    wr(8'h20, 32'h03);
    ticks(10, 0);
    rd(8'h28, v); check("R4 count holds compare", v, 3);
    rd(8'h20, v); check("R4 enable cleared", v, 0);
    rd(8'h08, v); check("R4 pending", v, 2);

    // R7 clear, alone and against a tick
    wr(8'h10, 32'h12);
    rd(8'h18, v); check("R7 clear zeroes", v, 0);
    wr(8'h1C, 100);
    wr(8'h10, 32'h13);
    ticks(6, 0);
    rd(8'h18, v); check("R7 precount", v, 6);
    tick_fast = 1'b1;
    wr(8'h10, 32'h13);
    tick_fast = 1'b0;
    rd(8'h18, v); check("R7 clear beats tick", v, 0);
    wr(8'h10, 32'h10);

    // R9 divide by two on channel 4
    wr(8'h44, 1);
    wr(8'h4C, 1000);
    wr(8'h40, 32'h13);
    ticks(7, 0);
    rd(8'h48, v); check("R9 half rate", v, 3);
    wr(8'h40, 32'h10);

    // R8 slow source on channel 5
    wr(8'h54, 32'h10);
    wr(8'h5C, 1000);
    wr(8'h50, 32'h13);
    ticks(5, 0);
    rd(8'h58, v); check("R8 fast ignored", v, 0);
    ticks(4, 1);
    rd(8'h58, v); check("R8 slow counted", v, 4);

    // R5 free-run wrap on channel 3 (narrow copy wraps)
    wr(8'h08, 32'h3F);
    wr(8'h3C, 4);
    wr(8'h30, 32'h33);
    ticks(260, 0);
    rd(8'h38, v); check("R5 wide count", v, 260);
    check("R5 narrow wrapped", rdata_n, 4);
    rd(8'h08, v); check("R5 no event", v & 32'h4, 0);
    check("R5 no event narrow", rdata_n & 32'h4, 0);

    // R11 set and acknowledge collide on channel 6
    wr(8'h6C, 0);
    wr(8'h60, 32'h13);
    tick_fast = 1'b1;
    wr(8'h08, 32'h20);
    tick_fast = 1'b0;
    rd(8'h08, v); check("R11 set wins", v & 32'h20, 32'h20);
    wr(8'h08, 32'h3F);
    rd(8'h08, v); check("R10 all cleared", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule